// File: doc/BRIEF.md
# Multi-Agent Steering Lock Semaphore

This block is a one-bit hardware lock, placed at register offset 0xFD0. Several agents, for example a host driver and on-chip firmware, share one steering selector, and the lock ensures that only one of them uses it at a time. Each agent has its own register port with a read strobe, a write strobe, an address and write data. A read of the lock register is also the attempt to acquire it. When the lock is free, the read returns 1 and the reader becomes the owner. When the lock is held, the read returns 0 and nothing changes. The owner gives the lock back by writing a value with bit 0 set.

A read response comes back exactly one cycle after the read strobe, on that port's `rsp_valid` and `rsp_data`. There is no back-pressure, so an agent must take each response in the cycle it appears. To wait for the lock, an agent polls: it keeps reading until it gets a 1, and gives up after a time limit of its own choosing. The lock has no timeout of its own. Two status pins show the lock state: `lock_busy`, and `lock_owner`, which holds the owner's index. If several agents try to acquire the free lock in the same cycle, the agent with the lowest index wins.

Top module: `steer_lock`

## Requirements
- R1: After reset, `lock_busy` is 0, `lock_owner` is 0 and every `rsp_valid` is 0. Whenever `lock_busy` is 0, `lock_owner` reads 0.
- R2: Agent k reads address 0xFD0 while the lock is free and no lower-indexed agent reads it in the same cycle. One cycle later, agent k sees `rsp_data` = 1, `lock_busy` is 1 and `lock_owner` is k.
- R3: While the lock is held, a read of 0xFD0 by any agent returns 0, and `lock_busy` and `lock_owner` keep their values.
- R4: When several agents read 0xFD0 in the same cycle while the lock is free, the lowest-indexed reader gets 1 and becomes owner, and every other reader gets 0.
- R5: The owner writes 0xFD0 with bit 0 of the write data set. One cycle later, `lock_busy` is 0 and `lock_owner` is 0.
- R6: These writes do not change `lock_busy` or `lock_owner`: a write by an agent that is not the owner, a write whose bit 0 is 0, and any write while the lock is free.
- R7: An access to any address other than 0xFD0 has no effect on the lock. A read of such an address returns 0.
- R8: `rsp_valid[k]` is 1 exactly one cycle after `rd_en[k]` was 1. `rsp_data` of port k is 0 in every cycle without a grant to port k.
- R9: At most one agent's response carries a 1 in any cycle.
- R10: The owner releases the lock in the same cycle that another agent reads it. The reader gets 0, and the lock is free one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | N_AGENTS | Read strobe for each agent |
| wr_en | input | N_AGENTS | Write strobe for each agent |
| addr | input | N_AGENTS*ADDR_W | Address for each agent; agent k uses bits [k*ADDR_W +: ADDR_W] |
| wdata | input | N_AGENTS*DATA_W | Write data for each agent; only bit 0 is used |
| rsp_valid | output | N_AGENTS | Read response valid, one cycle after `rd_en` |
| rsp_data | output | N_AGENTS*DATA_W | Read response data for each agent; 1 means the lock was granted |
| lock_busy | output | 1 | The lock is held |
| lock_owner | output | IDX_W | Index of the owner; 0 while the lock is free |

## Verification
A wrong lock state shows at the ports within one cycle. If the busy flag is lost, a second agent's read returns 1 while the first agent still holds the lock. If the owner index is corrupted, the real owner's release write is ignored and `lock_busy` stays 1 from then on. A priority error hands the 1 to a higher-indexed reader in the cycle after a contended read. The bench keeps a reference copy of the busy flag and owner index. After every clock it compares the model against each port's response and against the status pins.

// File: rtl/steer_lock_pkg.sv
package steer_lock_pkg;
  // Width of an index into a group of n agents (at least 1 bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/steer_lock_dec.sv
module steer_lock_dec #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'hFD0
) (
  input  logic [N_AGENTS-1:0]        rd_en,
  input  logic [N_AGENTS-1:0]        wr_en,
  input  logic [N_AGENTS*ADDR_W-1:0] addr,
  input  logic [N_AGENTS*DATA_W-1:0] wdata,
  output logic [N_AGENTS-1:0]        take_req,
  output logic [N_AGENTS-1:0]        give_req
);
  for (genvar k = 0; k < N_AGENTS; k++) begin : g_port
    logic at_lock;
    assign at_lock     = (addr[k*ADDR_W +: ADDR_W] == LOCK_ADDR);
    assign take_req[k] = rd_en[k] && at_lock;
    assign give_req[k] = wr_en[k] && at_lock && wdata[k*DATA_W];
  end
endmodule

// File: rtl/steer_lock_pick.sv
module steer_lock_pick #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [N_AGENTS-1:0] req,
  output logic [N_AGENTS-1:0] gnt,
  output logic [IDX_W-1:0]    gnt_idx,
  output logic                gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int i = N_AGENTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IDX_W'(i);
        gnt_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/steer_lock_state.sv
module steer_lock_state #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_any,
  input  logic [IDX_W-1:0]    take_idx,
  input  logic [N_AGENTS-1:0] give_req,
  output logic                busy,
  output logic [IDX_W-1:0]    owner
);
  logic give_ok;
  assign give_ok = busy && give_req[owner];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (!busy && take_any) begin
      busy  <= 1'b1;
      owner <= take_idx;
    end else if (give_ok) begin
      busy  <= 1'b0;
      owner <= '0;
    end
  end

  p_acquire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && take_any) |=> (busy && owner == $past(take_idx)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !give_ok) |=> (busy && $stable(owner)));
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    give_ok |=> !busy);
  p_free_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take_any) |=> !busy);
  p_free_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (owner == '0));
endmodule

// File: rtl/steer_lock_resp.sv
module steer_lock_resp #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_AGENTS-1:0]        rd_en,
  input  logic [N_AGENTS-1:0]        grant,
  output logic [N_AGENTS-1:0]        rsp_valid,
  output logic [N_AGENTS*DATA_W-1:0] rsp_data
);
  logic [N_AGENTS-1:0] won;

  for (genvar k = 0; k < N_AGENTS; k++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[k] <= 1'b0;
        won[k]       <= 1'b0;
      end else begin
        rsp_valid[k] <= rd_en[k];
        won[k]       <= grant[k];
      end
    end
    assign rsp_data[k*DATA_W +: DATA_W] = DATA_W'(won[k]);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[k] |=> rsp_valid[k]);
    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[k] |=> !rsp_valid[k]);
    p_win_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      won[k] |-> rsp_valid[k]);
  end

  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(won));
endmodule

// File: rtl/steer_lock.sv
module steer_lock #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'hFD0,
  localparam int unsigned IDX_W = steer_lock_pkg::idx_width(N_AGENTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_AGENTS-1:0]        rd_en,
  input  logic [N_AGENTS-1:0]        wr_en,
  input  logic [N_AGENTS*ADDR_W-1:0] addr,
  input  logic [N_AGENTS*DATA_W-1:0] wdata,
  output logic [N_AGENTS-1:0]        rsp_valid,
  output logic [N_AGENTS*DATA_W-1:0] rsp_data,
  output logic                       lock_busy,
  output logic [IDX_W-1:0]           lock_owner
);
  logic [N_AGENTS-1:0] take_req, give_req, pick_gnt, grant;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_any;

  steer_lock_dec #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .LOCK_ADDR(LOCK_ADDR)) i_dec (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .take_req(take_req), .give_req(give_req));

  steer_lock_pick #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) i_pick (
    .req(take_req), .gnt(pick_gnt), .gnt_idx(pick_idx), .gnt_any(pick_any));

  steer_lock_state #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) i_state (
    .clk(clk), .rst_n(rst_n), .take_any(pick_any), .take_idx(pick_idx),
    .give_req(give_req), .busy(lock_busy), .owner(lock_owner));

  // A grant only exists while the lock is free at the time of the read.
  assign grant = lock_busy ? '0 : pick_gnt;

  steer_lock_resp #(.N_AGENTS(N_AGENTS), .DATA_W(DATA_W)) i_resp (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .grant(grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  p_held_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |=> (rsp_data == '0));
endmodule

// File: tb/test_steer_lock.sv
module test_steer_lock;
  localparam int N = 4;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam logic [AW-1:0] LOCK = 12'hFD0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    rd_en = '0, wr_en = '0;
  logic [AW-1:0]   a_addr [N];
  logic [DW-1:0]   a_wdata [N];
  logic [N*AW-1:0] addr;
  logic [N*DW-1:0] wdata;
  logic [N-1:0]    rsp_valid;
  logic [N*DW-1:0] rsp_data;
  logic            lock_busy;
  logic [IW-1:0]   lock_owner;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      addr[k*AW +: AW]  = a_addr[k];
      wdata[k*DW +: DW] = a_wdata[k];
    end
  end

  steer_lock #(.N_AGENTS(N), .ADDR_W(AW), .DATA_W(DW), .LOCK_ADDR(LOCK)) i_steer_lock (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .lock_busy(lock_busy), .lock_owner(lock_owner));

  int checks = 0, failures = 0;
  bit m_busy = 1'b0;
  int m_owner = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bool_t_dummy(); endfunction

  function automatic bit takes(input int k);
    return rd_en[k] && a_addr[k] == LOCK;
  endfunction
  function automatic bit gives(input int k);
    return wr_en[k] && a_addr[k] == LOCK && a_wdata[k][0];
  endfunction

  task automatic idle_all();
    rd_en = '0; wr_en = '0;
    for (int k = 0; k < N; k++) begin a_addr[k] = LOCK; a_wdata[k] = '0; end
  endtask

  // Compute expected results of the current inputs, clock once, compare.
  task automatic cycle();
    int win = -1, nreq = 0;
    bit n_busy; int n_owner;
    bit foreign_w = 1'b0;
    bit owner_gives;
    int exp_d [N];
    string stag;
    for (int k = 0; k < N; k++) if (takes(k)) begin nreq++; if (win < 0) win = k; end
    owner_gives = m_busy && gives(m_owner);
    for (int k = 0; k < N; k++) if (wr_en[k] && !(m_busy && k == m_owner && gives(k))) foreign_w = 1'b1;
    n_busy = m_busy; n_owner = m_owner;
    if (!m_busy && win >= 0) begin n_busy = 1'b1; n_owner = win; end
    else if (owner_gives) begin n_busy = 1'b0; n_owner = 0; end
    for (int k = 0; k < N; k++) exp_d[k] = (!m_busy && k == win) ? 1 : 0;
    @(posedge clk); #1;
    for (int k = 0; k < N; k++) begin
      string t;
      chk(rsp_valid[k] == rd_en[k], "R8 rsp_valid", rsp_valid[k], rd_en[k]);
      if (!rd_en[k]) t = "R8 idle data";
      else if (a_addr[k] != LOCK) t = "R7 other address read";
      else if (m_busy && owner_gives) t = "R10 read during release";
      else if (m_busy) t = "R3 read while held";
      else if (nreq > 1) t = "R4 contended read";
      else t = "R2 acquire read";
      chk(rsp_data[k*DW +: DW] == DW'(exp_d[k]), t, int'(rsp_data[k*DW +: DW]), exp_d[k]);
    end
    chk($countones(rsp_data) <= 1, "R9 single winner", $countones(rsp_data), 1);
    if (owner_gives) stag = "R5 release";
    else if (foreign_w) stag = "R6 ignored write";
    else if (!m_busy && win >= 0) stag = "R2 acquire";
    else stag = "R3 hold";
    chk(lock_busy == n_busy, {stag, " busy"}, lock_busy, n_busy);
    chk(int'(lock_owner) == n_owner, {stag, " owner"}, int'(lock_owner), n_owner);
    if (!n_busy) chk(lock_owner == '0, "R1 free owner zero", int'(lock_owner), 0);
    m_busy = n_busy; m_owner = n_owner;
    idle_all();
  endtask

  // Agent polls the lock; optionally the current owner releases at iteration rel_at.
  task automatic poll(input int agent, input int limit, input int rel_at,
                      output bit got, output int tries);
    got = 1'b0; tries = 0;
    while (!got && tries < limit) begin
      rd_en[agent] = 1'b1; a_addr[agent] = LOCK;
      if (tries == rel_at && m_busy) begin
        wr_en[m_owner] = 1'b1; a_wdata[m_owner] = 32'h1;
      end
      cycle();
      got = rsp_data[agent*DW] == 1'b1;
      tries++;
    end
  endtask

  initial begin
    bit got; int tries;
    void'($urandom(32'd1234));
    idle_all();
    repeat (3) @(posedge clk);
    #1;
    chk(lock_busy == 1'b0, "R1 reset busy", lock_busy, 0);
    chk(lock_owner == '0, "R1 reset owner", int'(lock_owner), 0);
    chk(rsp_valid == '0, "R1 reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    rd_en[1] = 1'b1; cycle();                                // R2
    rd_en[0] = 1'b1; rd_en[3] = 1'b1; cycle();               // R3
    wr_en[0] = 1'b1; a_wdata[0] = 32'h1; cycle();            // R6 non-owner
    wr_en[1] = 1'b1; a_wdata[1] = 32'h2; cycle();            // R6 bit0 clear
    wr_en[1] = 1'b1; a_wdata[1] = 32'h1; a_addr[1] = 12'hFD4; cycle(); // R7
    rd_en[2] = 1'b1; a_addr[2] = 12'h100; cycle();           // R7 read elsewhere
    wr_en[1] = 1'b1; a_wdata[1] = 32'h1; rd_en[2] = 1'b1; cycle(); // R10
    wr_en[3] = 1'b1; a_wdata[3] = 32'h1; cycle();            // R6 write while free
    rd_en[3] = 1'b1; rd_en[2] = 1'b1; cycle();               // R4
    wr_en[2] = 1'b1; a_wdata[2] = 32'h1; cycle();            // R5
    rd_en = '1; cycle();                                     // R4 all
    chk(m_owner == 0, "R4 lowest wins", int'(lock_owner), 0);

    // Owner never releases: poller gives up at its own limit (R3).
    poll(2, 40, -1, got, tries);
    chk(!got, "R3 poll timeout", got, 0);
    // Owner releases mid-poll: poller acquires right after (R5, R2).
    poll(3, 40, 15, got, tries);
    chk(got && tries == 17, "R2 poll acquire after release", tries, 17);
    wr_en[3] = 1'b1; a_wdata[3] = 32'h1; cycle();

    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < N; k++) begin
        rd_en[k]   = ($urandom % 10) < 3;
        wr_en[k]   = ($urandom % 10) < 2;
        a_addr[k]  = (($urandom % 10) < 8) ? LOCK : AW'($urandom);
        a_wdata[k] = $urandom;
      end
      cycle();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule